// File: doc/BRIEF.md
# Condition and Special Register Move Unit

This block holds a 32-bit condition word split into eight 4-bit fields and a bank of four 64-bit special registers: a fixed-point status register, a return-link register, a loop-count register and a branch-target register. It carries out the transfer operations that move data between these registers and a 64-bit general-purpose data port. An upstream decoder presents a 10-bit extended opcode, a 10-bit special register number, an 8-bit field-enable mask, a 3-bit field selector and a source value, all qualified by a single valid strobe.

Reads are combinational from the current register contents. Writes land on the rising clock edge that samples the strobe. Two operations go beyond plain copies. A masked condition write replaces only the fields whose mask bit is set. A flag transfer moves the four status bits 31:28 into one selected condition field and then clears those four bits in the status register. A special register number outside the four supported values, or an unsupported opcode, raises an illegal flag and leaves every register untouched.

Top module: `cond_spr_move_unit`

## Requirements
- R1: After reset (active-low `rst_n`), the condition word and all four special registers read zero, `rd_val` is zero and `illegal` is low.
- R2: Opcode 467 writes `src_val` into the special register chosen by `spr_num` on the next rising edge: 0x020 is the status register, 0x100 the link register, 0x120 the count register and 0x1F9 the target register. The other registers keep their values.
- R3: Opcode 339 puts the selected special register (same number mapping as R2) on `rd_val` in the same cycle, with no state change.
- R4: For opcodes 339 or 467 with any other `spr_num`, `illegal` is high, `rd_val` is zero, and no register changes.
- R5: Opcode 144 loads `src_val[4i+3:4i]` into condition bits 4i+3:4i for each i where `field_mask[i]` is 1. Fields whose mask bit is 0 keep their old value, so a zero mask changes nothing.
- R6: Opcode 19 puts the condition word on `rd_val[31:0]`, with `rd_val[63:32]` zero, and changes no state.
- R7: Opcode 512 copies status bits 31:28 into condition field k = `field_sel`, which occupies bits 31-4k down to 28-4k. Field 0 is the most significant nibble and field 7 is bits 3:0. The same edge clears status bits 31:28 and leaves status bits 63:32 and 27:0 unchanged.
- R8: While `op_valid` is low, no register changes and `illegal` is low. When `op_valid` is high with an opcode outside {19, 144, 339, 467, 512}, `illegal` is high and no register changes.
- R9: A read issued in the same cycle as a write returns the value from before that write. The new value is visible from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_xo | input | 10 | Extended opcode |
| spr_num | input | 10 | Special register number |
| field_mask | input | 8 | Per-field write enable for masked condition write |
| field_sel | input | 3 | Condition field index for flag transfer |
| src_val | input | 64 | General-purpose source value |
| rd_val | output | 64 | Combinational read result |
| illegal | output | 1 | Unsupported opcode or special register number |
| cond_q | output | 32 | Current condition word |
| fx_q | output | 64 | Current status register |
| link_q | output | 64 | Current link register |
| count_q | output | 64 | Current count register |
| target_q | output | 64 | Current target register |

## Verification
The masked condition write is exercised with masks of all zeros, all ones, single bits and random patterns. These patterns show whether the mask-to-nibble mapping is reversed, shifted, or leaks into disabled fields. The flag transfer is driven with selectors 0 and 7 and with random selectors over a status register with a distinctive top nibble. This shows that field 0 sits at the most significant nibble and that only status bits 31:28 are cleared. Special register numbers adjacent to the valid values, including random numbers, check that the number decode is exact and that illegal accesses leave all state intact. Back-to-back write-then-read sequences confirm the one-edge write latency and that a same-cycle read returns the old value.

// File: rtl/cond_spr_move_pkg.sv
package cond_spr_move_pkg;

    localparam int XO_W      = 10;
    localparam int SPRN_W    = 10;
    localparam int GPR_W     = 64;
    localparam int FIELD_W   = 4;
    localparam int N_FIELDS  = 8;
    localparam int COND_W    = FIELD_W * N_FIELDS;
    localparam int SEL_W     = $clog2(N_FIELDS);
    localparam int N_SPR     = 4;
    localparam int SPR_IDX_W = $clog2(N_SPR);
    // status bits that feed the flag transfer
    localparam int FLAG_HI   = 31;
    localparam int FLAG_LO   = FLAG_HI - FIELD_W + 1;

    localparam logic [XO_W-1:0] XO_SPR_RD   = 10'd339;
    localparam logic [XO_W-1:0] XO_SPR_WR   = 10'd467;
    localparam logic [XO_W-1:0] XO_COND_WR  = 10'd144;
    localparam logic [XO_W-1:0] XO_COND_RD  = 10'd19;
    localparam logic [XO_W-1:0] XO_FLAG_MV  = 10'd512;

    localparam logic [SPRN_W-1:0] SPRN_FX   = 10'h020;
    localparam logic [SPRN_W-1:0] SPRN_LNK  = 10'h100;
    localparam logic [SPRN_W-1:0] SPRN_CNT  = 10'h120;
    localparam logic [SPRN_W-1:0] SPRN_TGT  = 10'h1F9;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_SPR_RD,
        OPK_SPR_WR,
        OPK_COND_WR,
        OPK_COND_RD,
        OPK_FLAG_MV
    } op_kind_e;

    typedef enum logic [SPR_IDX_W-1:0] {
        SPR_FX  = 2'd0,
        SPR_LNK = 2'd1,
        SPR_CNT = 2'd2,
        SPR_TGT = 2'd3
    } spr_id_e;

endpackage

// File: rtl/csm_op_decode.sv
module csm_op_decode
    import cond_spr_move_pkg::*;
(
    input  logic [XO_W-1:0] xo,
    output op_kind_e        kind
);

    always_comb begin
        unique case (xo)
            XO_SPR_RD:  kind = OPK_SPR_RD;
            XO_SPR_WR:  kind = OPK_SPR_WR;
            XO_COND_WR: kind = OPK_COND_WR;
            XO_COND_RD: kind = OPK_COND_RD;
            XO_FLAG_MV: kind = OPK_FLAG_MV;
            default:    kind = OPK_NONE;
        endcase
    end

endmodule

// File: rtl/csm_spr_select.sv
module csm_spr_select
    import cond_spr_move_pkg::*;
(
    input  logic [SPRN_W-1:0] num,
    output spr_id_e           id,
    output logic              hit
);

    always_comb begin
        hit = 1'b1;
        unique case (num)
            SPRN_FX:  id = SPR_FX;
            SPRN_LNK: id = SPR_LNK;
            SPRN_CNT: id = SPR_CNT;
            SPRN_TGT: id = SPR_TGT;
            default: begin
                id  = SPR_FX;
                hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csm_cond_merge.sv
module csm_cond_merge
    import cond_spr_move_pkg::*;
(
    input  op_kind_e            kind,
    input  logic [COND_W-1:0]   cond_cur,
    input  logic [COND_W-1:0]   src,
    input  logic [N_FIELDS-1:0] mask,
    input  logic [SEL_W-1:0]    sel,
    input  logic [FIELD_W-1:0]  flag_nib,
    output logic [COND_W-1:0]   cond_next
);

    // Nibble g is enabled by mask bit g; flag transfer numbers fields from the top.
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(N_FIELDS - 1 - g);
        logic take_src;
        logic take_flag;

        assign take_src  = (kind == OPK_COND_WR) && mask[g];
        assign take_flag = (kind == OPK_FLAG_MV) && (sel == TOP_IDX);

        always_comb begin
            if (take_src)
                cond_next[g*FIELD_W +: FIELD_W] = src[g*FIELD_W +: FIELD_W];
            else if (take_flag)
                cond_next[g*FIELD_W +: FIELD_W] = flag_nib;
            else
                cond_next[g*FIELD_W +: FIELD_W] = cond_cur[g*FIELD_W +: FIELD_W];
        end
    end

endmodule

// File: rtl/cond_spr_move_unit.sv
module cond_spr_move_unit
    import cond_spr_move_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [XO_W-1:0]     op_xo,
    input  logic [SPRN_W-1:0]   spr_num,
    input  logic [N_FIELDS-1:0] field_mask,
    input  logic [SEL_W-1:0]    field_sel,
    input  logic [GPR_W-1:0]    src_val,
    output logic [GPR_W-1:0]    rd_val,
    output logic                illegal,
    output logic [COND_W-1:0]   cond_q,
    output logic [GPR_W-1:0]    fx_q,
    output logic [GPR_W-1:0]    link_q,
    output logic [GPR_W-1:0]    count_q,
    output logic [GPR_W-1:0]    target_q
);

    op_kind_e          kind;
    spr_id_e           spr_id;
    logic              spr_hit;
    logic              spr_op;
    logic              commit;
    logic [COND_W-1:0] cond_next;
    logic [GPR_W-1:0]  spr_q [N_SPR];

    csm_op_decode i_dec (
        .xo   (op_xo),
        .kind (kind)
    );

    csm_spr_select i_sel (
        .num (spr_num),
        .id  (spr_id),
        .hit (spr_hit)
    );

    csm_cond_merge i_merge (
        .kind      (kind),
        .cond_cur  (cond_q),
        .src       (src_val[COND_W-1:0]),
        .mask      (field_mask),
        .sel       (field_sel),
        .flag_nib  (spr_q[SPR_FX][FLAG_HI:FLAG_LO]),
        .cond_next (cond_next)
    );

    assign spr_op  = (kind == OPK_SPR_RD) || (kind == OPK_SPR_WR);
    assign illegal = op_valid && ((kind == OPK_NONE) || (spr_op && !spr_hit));
    assign commit  = op_valid && !illegal;

    // condition word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cond_q <= '0;
        else if (commit && ((kind == OPK_COND_WR) || (kind == OPK_FLAG_MV)))
            cond_q <= cond_next;
    end

    // special register bank
    for (genvar s = 0; s < N_SPR; s++) begin : g_spr
        localparam spr_id_e MY_ID = spr_id_e'(s);
        logic wr_this;
        logic clr_flags;

        assign wr_this   = commit && (kind == OPK_SPR_WR) && (spr_id == MY_ID);
        assign clr_flags = commit && (kind == OPK_FLAG_MV) && (MY_ID == SPR_FX);

        always_ff @(posedge clk) begin
            if (!rst_n)
                spr_q[s] <= '0;
            else if (wr_this)
                spr_q[s] <= src_val;
            else if (clr_flags)
                spr_q[s][FLAG_HI:FLAG_LO] <= '0;
        end
    end

    // combinational read path
    always_comb begin
        rd_val = '0;
        if (op_valid && !illegal) begin
            unique case (kind)
                OPK_SPR_RD:  rd_val = spr_q[spr_id];
                OPK_COND_RD: rd_val = {{(GPR_W-COND_W){1'b0}}, cond_q};
                default:     rd_val = '0;
            endcase
        end
    end

    assign fx_q     = spr_q[SPR_FX];
    assign link_q   = spr_q[SPR_LNK];
    assign count_q  = spr_q[SPR_CNT];
    assign target_q = spr_q[SPR_TGT];

    // R4
    illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> ($stable(cond_q) && $stable(fx_q) && $stable(link_q)
                     && $stable(count_q) && $stable(target_q)));

    // R8
    idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(cond_q) && $stable(fx_q) && $stable(link_q)
                       && $stable(count_q) && $stable(target_q)));

    // R8
    idle_not_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !illegal);

    // R7
    flag_move_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_xo == XO_FLAG_MV) |=> (fx_q[FLAG_HI:FLAG_LO] == '0
            && $stable(fx_q[FLAG_LO-1:0]) && $stable(fx_q[GPR_W-1:FLAG_HI+1])));

    // R5
    zero_mask_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_xo == XO_COND_WR && field_mask == '0) |=> $stable(cond_q));

    // R6
    cond_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_xo == XO_COND_RD) |-> (rd_val[GPR_W-1:COND_W] == '0));

endmodule

// File: tb/test_cond_spr_move_unit.sv
`timescale 1ns/1ps
module test_cond_spr_move_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [9:0]  op_xo = '0;
    logic [9:0]  spr_num = '0;
    logic [7:0]  field_mask = '0;
    logic [2:0]  field_sel = '0;
    logic [63:0] src_val = '0;
    logic [63:0] rd_val;
    logic        illegal;
    logic [31:0] cond_q;
    logic [63:0] fx_q, link_q, count_q, target_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state
    logic [31:0] m_cond;
    logic [63:0] m_spr [4];

    always #2.5 clk = ~clk;

    cond_spr_move_unit i_cond_spr_move_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_xo(op_xo),
        .spr_num(spr_num), .field_mask(field_mask), .field_sel(field_sel),
        .src_val(src_val), .rd_val(rd_val), .illegal(illegal),
        .cond_q(cond_q), .fx_q(fx_q), .link_q(link_q), .count_q(count_q),
        .target_q(target_q)
    );

    function automatic int spr_index(input logic [9:0] n);
        case (n)
            10'h020: return 0;
            10'h100: return 1;
            10'h120: return 2;
            10'h1F9: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic bit known_xo(input logic [9:0] x);
        return (x == 10'd339) || (x == 10'd467) || (x == 10'd144)
            || (x == 10'd19) || (x == 10'd512);
    endfunction

    function automatic bit exp_illegal(input bit v, input logic [9:0] x, input logic [9:0] n);
        if (!v) return 1'b0;
        if (!known_xo(x)) return 1'b1;
        if ((x == 10'd339 || x == 10'd467) && spr_index(n) < 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [63:0] exp_rd(input bit v, input logic [9:0] x, input logic [9:0] n);
        if (!v || exp_illegal(v, x, n)) return 64'd0;
        if (x == 10'd339) return m_spr[spr_index(n)];
        if (x == 10'd19)  return {32'd0, m_cond};
        return 64'd0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(cond_q == m_cond,     req, {32'd0, cond_q}, {32'd0, m_cond});
        check(fx_q == m_spr[0],     req, fx_q, m_spr[0]);
        check(link_q == m_spr[1],   req, link_q, m_spr[1]);
        check(count_q == m_spr[2],  req, count_q, m_spr[2]);
        check(target_q == m_spr[3], req, target_q, m_spr[3]);
    endtask

    task automatic model_update(input bit v, input logic [9:0] x, input logic [9:0] n,
                                input logic [7:0] mk, input logic [2:0] sl, input logic [63:0] s);
        if (!v || exp_illegal(v, x, n)) return;
        if (x == 10'd467) m_spr[spr_index(n)] = s;
        if (x == 10'd144)
            for (int i = 0; i < 8; i++)
                if (mk[i]) m_cond[4*i +: 4] = s[4*i +: 4];
        if (x == 10'd512) begin
            m_cond[(7 - sl)*4 +: 4] = m_spr[0][31:28];
            m_spr[0][31:28] = 4'd0;
        end
    endtask

    // apply one operation; reads checked same cycle, state after edge
    task automatic do_op(input bit v, input logic [9:0] x, input logic [9:0] n,
                         input logic [7:0] mk, input logic [2:0] sl, input logic [63:0] s,
                         input string req);
        logic [63:0] e_rd;
        bit          e_il;
        @(negedge clk);
        op_valid = v; op_xo = x; spr_num = n; field_mask = mk; field_sel = sl; src_val = s;
        #1;
        e_rd = exp_rd(v, x, n);
        e_il = exp_illegal(v, x, n);
        check(rd_val == e_rd, req, rd_val, e_rd);
        check(illegal == e_il, req, {63'd0, illegal}, {63'd0, e_il});
        model_update(v, x, n, mk, sl, s);
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        check_state(req);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] xos [7];
        logic [9:0] nums [4];
        int dummy;
        dummy = $urandom(32'd1234);
        xos  = '{10'd339, 10'd467, 10'd144, 10'd19, 10'd512, 10'd0, 10'd145};
        nums = '{10'h020, 10'h100, 10'h120, 10'h1F9};
        m_cond = '0;
        for (int i = 0; i < 4; i++) m_spr[i] = '0;

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_state("R1");
        check(rd_val == 64'd0, "R1", rd_val, 64'd0);
        check(illegal == 1'b0, "R1", {63'd0, illegal}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3 each special register written then read
        do_op(1, 10'd467, 10'h020, 8'h00, 3'd0, 64'hA5A5_0000_C123_4567, "R2");
        do_op(1, 10'd467, 10'h100, 8'h00, 3'd0, 64'h1111_2222_3333_4444, "R2");
        do_op(1, 10'd467, 10'h120, 8'h00, 3'd0, 64'hDEAD_BEEF_0000_0001, "R2");
        do_op(1, 10'd467, 10'h1F9, 8'h00, 3'd0, 64'h0123_4567_89AB_CDEF, "R2");
        for (int i = 0; i < 4; i++) do_op(1, 10'd339, nums[i], 8'h00, 3'd0, 64'd0, "R3");

        // R4 neighbours of valid numbers
        do_op(1, 10'd467, 10'h021, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        do_op(1, 10'd467, 10'h1F8, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        do_op(1, 10'd339, 10'h101, 8'h00, 3'd0, 64'd0, "R4");

        // R5 masks: full, empty, single bits
        do_op(1, 10'd144, 10'h0, 8'hFF, 3'd0, 64'h0000_0000_8765_4321, "R5");
        do_op(1, 10'd144, 10'h0, 8'h00, 3'd0, 64'h0000_0000_FFFF_FFFF, "R5");
        do_op(1, 10'd144, 10'h0, 8'h01, 3'd0, 64'h0000_0000_FFFF_FFFF, "R5");
        do_op(1, 10'd144, 10'h0, 8'h80, 3'd0, 64'h0000_0000_0000_0000, "R5");
        do_op(1, 10'd144, 10'h0, 8'h5A, 3'd0, 64'hFFFF_FFFF_9ABC_DEF0, "R5");

        // R6 condition read
        do_op(1, 10'd19, 10'h0, 8'h00, 3'd0, 64'd0, "R6");

        // R7 flag transfer at both ends (status top nibble is 0xC)
        do_op(1, 10'd512, 10'h0, 8'h00, 3'd0, 64'd0, "R7");
        do_op(1, 10'd467, 10'h020, 8'h00, 3'd0, 64'h7777_7777_B777_7777, "R7");
        do_op(1, 10'd512, 10'h0, 8'h00, 3'd7, 64'd0, "R7");
        do_op(1, 10'd19, 10'h0, 8'h00, 3'd0, 64'd0, "R7");

        // R8 idle strobe and unknown opcode
        do_op(0, 10'd467, 10'h100, 8'hFF, 3'd0, 64'h5555_5555_5555_5555, "R8");
        do_op(0, 10'd144, 10'h0, 8'hFF, 3'd0, 64'h5555_5555_5555_5555, "R8");
        do_op(1, 10'd145, 10'h100, 8'hFF, 3'd2, 64'h5555_5555_5555_5555, "R8");

        // R9 write then read back-to-back
        do_op(1, 10'd467, 10'h120, 8'h00, 3'd0, 64'h0F0F_0F0F_0F0F_0F0F, "R9");
        do_op(1, 10'd339, 10'h120, 8'h00, 3'd0, 64'd0, "R9");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [9:0] x, n;
            bit v;
            v = ($urandom % 8) != 0;
            x = xos[$urandom % 7];
            n = (($urandom % 5) == 0) ? 10'($urandom) : nums[$urandom % 4];
            do_op(v, x, n, 8'($urandom), 3'($urandom), {$urandom, $urandom}, "R9");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule